// File: doc/BRIEF.md
# Coherent Dual-Parameter Transfer Controller

The block moves a pair of 32-bit parameters between a two-word slot of a parameter buffer and two independently chosen words of a shared data memory. The pair moves as one operation that no other host access can interleave with. The host programs one 32-bit control word. That word selects:
- a direction,
- a width,
- a five-bit channel base,
- two seven-bit parameter numbers,
- a ten-bit buffer slot.

Setting the top bit of the same write launches the move. The block then holds the host bus with a wait signal until both parameters have arrived.

Each parameter takes one memory read cycle and then one memory write cycle. The memory answers a read one cycle later, and the write cycle forwards that word. Parameter 0 always moves before parameter 1. In 24-bit mode the write carries byte enables `0111`, so the top byte of the destination word keeps its old value without a read-modify-write.

Top module: `coh_pair_mover`

## Requirements
- R1: The control word places its fields as follows: [31] go/busy, [30:26] channel base, [25:16] buffer slot, [15] width (1 = 32-bit), [14:8] parameter-0 number, [7] direction (1 = buffer to targets), [6:0] parameter-1 number. A host write taken while idle stores bits [30:0]. `host_rdata` returns the stored bits with bit 31 equal to busy.
- R2: A host write taken while idle with bit 31 = 1 starts a transfer. A write with bit 31 = 0 stores the fields and starts nothing.
- R3: `host_wait` is high for exactly four cycles, beginning the cycle after the starting write. When it falls, status bit 31 reads 0.
- R4: The target word address of parameter k is BASE_WORD + {channel base, parameter-k number}.
- R5: The buffer word address of parameter k is BASE_WORD + 2 × buffer slot + k.
- R6: Memory writes use byte enables 1111 in 32-bit mode and 0111 in 24-bit mode. In 24-bit mode the destination's bits [31:24] keep their old value.
- R7: Direction 0 copies the targets into the buffer. Direction 1 copies the buffer into the targets.
- R8: The transfer runs in this order: read P0 source, write P0 destination, read P1 source, write P1 destination. Each write stores the word read in the cycle before it, so when addresses overlap, P1 sees P0's result.
- R9: Host writes made while busy change neither the stored fields nor memory.
- R10: `mem_re` and `mem_we` are never high together, and every write cycle directly follows a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Control word readback with busy in bit 31 |
| host_wait | output | 1 | Wait-state to the host while a transfer runs |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables for the write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench builds the block with AW = 13 and BASE_WORD = 2048. With these values every target index and every buffer slot maps to a distinct word in an 8192-word memory model, so the bench compares the whole model against its reference after each transfer. A nonzero base catches a missing offset term. Directed cases put a buffer slot on top of the two target words and also give P0 and P1 the same number, which makes the required ordering visible in the final memory contents. Random control words cover both widths and both directions, and some include a write during the busy window.

// File: rtl/coh_pair_mover.sv
module coh_pair_mover #(
  parameter int AW        = 14,
  parameter int BASE_WORD = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          host_wait,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_WR0, S_RD1, S_WR1} st_t;

  st_t         st;
  logic [30:0] cfg;

  logic [4:0] chan;
  logic [9:0] slot;
  logic       wide, to_tgt;
  logic [6:0] num0, num1;
  assign chan   = cfg[30:26];
  assign slot   = cfg[25:16];
  assign wide   = cfg[15];
  assign num0   = cfg[14:8];
  assign to_tgt = cfg[7];
  assign num1   = cfg[6:0];

  logic busy, second, use_tgt;
  assign busy    = (st != S_IDLE);
  assign mem_re  = (st == S_RD0) || (st == S_RD1);
  assign mem_we  = (st == S_WR0) || (st == S_WR1);
  assign second  = (st == S_RD1) || (st == S_WR1);
  assign use_tgt = mem_re ^ to_tgt;

  logic [11:0]   tidx;
  logic [10:0]   bidx;
  logic [AW-1:0] taddr, baddr;
  assign tidx  = {chan, second ? num1 : num0};
  assign bidx  = {slot, second};
  assign taddr = AW'(BASE_WORD) + AW'(tidx);
  assign baddr = AW'(BASE_WORD) + AW'(bidx);

  assign mem_addr   = use_tgt ? taddr : baddr;
  assign mem_be     = mem_we ? (wide ? 4'b1111 : 4'b0111) : 4'b0000;
  assign mem_wdata  = mem_rdata;
  assign host_wait  = busy;
  assign host_rdata = {busy, cfg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cfg <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_wr) begin
          cfg <= host_wdata[30:0];
          if (host_wdata[31]) st <= S_RD0;
        end
        S_RD0:   st <= S_WR0;
        S_WR0:   st <= S_RD1;
        S_RD1:   st <= S_WR1;
        S_WR1:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_wait && host_wdata[31]) |=> host_wait);
  assert_nostart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_wait && !host_wdata[31]) |=> !host_wait);
  assert_done_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_wait) |-> !host_rdata[31]);
  assert_be_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 4'b1111 || mem_be == 4'b0111));
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wait && host_wr) |=> $stable(host_rdata[30:0]));
  assert_rw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  assert_wr_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);
  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> $past(mem_re));

endmodule

// File: tb/tb_coh_pair_mover.sv
module tb_coh_pair_mover;
  localparam int AW   = 13;
  localparam int BASE = 2048;
  localparam int MW   = 1 << AW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          host_wr = 0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          host_wait;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;

  logic [31:0] mem  [MW];
  logic [31:0] refm [MW];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  coh_pair_mover #(.AW(AW), .BASE_WORD(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_wait(host_wait), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) for (int b = 0; b < 4; b++)
      if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  function automatic int tgt_w(logic [31:0] c, int k);
    return BASE + int'({c[30:26], (k == 0) ? c[14:8] : c[6:0]});
  endfunction
  function automatic int buf_w(logic [31:0] c, int k);
    return BASE + 2 * int'(c[25:16]) + k;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(logic [31:0] c);
    for (int k = 0; k < 2; k++) begin
      int s, d;
      s = c[7] ? buf_w(c, k) : tgt_w(c, k);
      d = c[7] ? tgt_w(c, k) : buf_w(c, k);
      refm[d] = c[15] ? refm[s] : {refm[d][31:24], refm[s][23:0]};
    end
  endtask

  task automatic cmp_mem(string req);
    int bad = -1;
    for (int i = 0; i < MW; i++) if (bad < 0 && mem[i] !== refm[i]) bad = i;
    if (bad < 0) check(1, req, "memory", 0, 0);
    else check(0, req, $sformatf("memory word %0d", bad), mem[bad], refm[bad]);
  endtask

  task automatic xfer(logic [31:0] c, bit poke, logic [31:0] pval);
    int cnt = 0;
    @(negedge clk); host_wr = 1; host_wdata = c | 32'h8000_0000;
    @(negedge clk); host_wr = 0;
    check(host_rdata[31] === 1'b1, "R1", "busy bit", host_rdata, 32'h8000_0000);
    while (host_wait && cnt < 20) begin
      cnt++;
      if (poke && cnt == 2) begin host_wr = 1; host_wdata = pval; end
      else host_wr = 0;
      @(negedge clk);
    end
    host_wr = 0;
    model(c | 32'h8000_0000);
    check(cnt == 4, "R3", "wait cycles", cnt, 4);
    check(host_rdata === {1'b0, c[30:0]}, poke ? "R9" : "R1", "readback",
          host_rdata, {1'b0, c[30:0]});
    cmp_mem(c[7] ? "R7/R4/R5/R6/R8 dir1" : "R7/R4/R5/R6/R8 dir0");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'd7719));
    for (int i = 0; i < MW; i++) begin mem[i] = $urandom; refm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    check(host_wait === 1'b0, "R3", "reset wait", host_wait, 0);
    check(host_rdata === 32'h0, "R1", "reset readback", host_rdata, 0);
    check(mem_re === 1'b0 && mem_we === 1'b0, "R10", "reset strobes", {mem_re, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: a write with bit 31 = 0 only stores the fields
    c = 32'h2A5C_D3B1 & 32'h7FFF_FFFF;
    host_wr = 1; host_wdata = c;
    @(negedge clk); host_wr = 0;
    check(host_wait === 1'b0, "R2", "no start wait", host_wait, 0);
    check(host_rdata === c, "R2", "no start readback", host_rdata, c);
    repeat (4) @(negedge clk);
    cmp_mem("R2 no start");

    // R8: the buffer slot overlaps both targets, direction 0, 32-bit
    c = {1'b0, 5'd1, 10'd66, 1'b1, 7'd5, 1'b0, 7'd4};
    xfer(c, 0, 0);
    // R6: 24-bit, direction 1, same target twice so P1 lands last
    c = {1'b0, 5'd3, 10'd500, 1'b0, 7'd9, 1'b1, 7'd9};
    xfer(c, 0, 0);
    // R6: 24-bit, direction 0
    c = {1'b0, 5'd31, 10'd1023, 1'b0, 7'd127, 1'b0, 7'd0};
    xfer(c, 0, 0);
    // R9: a write arrives while busy
    c = {1'b0, 5'd7, 10'd12, 1'b1, 7'd1, 1'b1, 7'd2};
    xfer(c, 1, 32'hFFFF_FFFF);

    for (int n = 0; n < 60; n++) begin
      c = $urandom;
      xfer(c, ($urandom % 4) == 0, $urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule